// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is an SPI slave that puts a byte-wide storage array of 2048 locations behind a four-wire serial link. A host drops chip select, then shifts in an opcode. Depending on the opcode, the host then sends a two-byte address followed by data bytes, or it reads back data or status. Reads and writes stream without limit. An internal address counter steps once per byte and wraps at the top of the array. Every written byte lands in the array the moment its last bit arrives, so there is no busy phase and the host never has to poll.

The serial pins are oversampled by a fast system clock. A two-stage synchronizer feeds edge detectors, so all state lives in one clock domain and the array can map onto block RAM. An active-low hold input freezes a transfer in mid-byte and floats the output; the transfer resumes at the same bit. Writes are guarded in three ways:

- a write-enable latch;
- two block-protect bits, which fence off part of the array;
- an active-low write-protect pin, which locks the status register.

The serial output is modelled as a data bit plus an enable, and the pad's tri-state buffer sits outside the block.

Top module: `spi_mem_slave`

## Requirements
- R1: SPI modes 0 and 3 both work: the input bit is taken on the rising serial clock edge and the output bit changes on the falling edge, MSB first.
- R2: While chip select is high, the serial clock and data input have no effect and miso_oe is low; a falling chip select starts a new opcode.
- R3: Opcodes are 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read, 0x02 write; any other opcode makes the rest of the transaction have no effect.
- R4: Read and write take a 16-bit address, high byte first, after the opcode; only its low 11 bits select the byte.
- R5: Reads and writes stream; the address steps by one per byte and wraps from 0x7FF to 0x000.
- R6: A written byte is stored when its eighth bit is received; a read started right after the write transaction returns it.
- R7: Array and status writes happen only while the write-enable latch is set; the latch is cleared by opcode 0x04, or by chip select rising after at least one data byte of a write or one status byte.
- R8: The status byte holds the write-enable latch in bit 1 and the block-protect field in bits 3:2, with all other bits zero; it repeats for as long as the host keeps clocking.
- R9: The block-protect field protects nothing (0), 0x600-0x7FF (1), 0x400-0x7FF (2) or the whole array (3); writes to protected bytes are dropped silently while the address still steps.
- R10: While wp_n is low, a status write leaves the block-protect field unchanged.
- R11: While hold_n is low, miso_oe is low and clock and chip-select edges are ignored; after release the transfer continues at the same bit.
- R12: miso_oe is high only while read data or status bits are being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer freeze |
| wp_n | input | 1 | Active-low status-register write lock |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the serial data out pad |

## Verification
The bound checker watches four conditions on every clock:

- miso_oe falls within three clocks of chip select going high, and within three clocks of hold going low;
- no array write strobe fires without the write-enable latch;
- no strobe ever hits a block the protect field fences off;
- the protect bits never change while the synchronized write-protect pin is low.

The rest can only be shown by the bench's serial transactions: the data values, the address decode and wrap, status contents, opcode decoding, bit-exact resumption after hold, and both clock polarities.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_WDATA, ST_RDATA, ST_RDSR, ST_WRSR, ST_SKIP
  } st_t;
endpackage

// File: rtl/spi_mem_sync.sv
`timescale 1ns/1ps
module spi_mem_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= {2{INIT[i]}};
      else     ff <= {ff[0], d[i]};
    end
    assign q[i] = ff[1];
  end
endmodule

// File: rtl/spi_mem_prot.sv
`timescale 1ns/1ps
module spi_mem_prot (
  input  logic [1:0] bp,
  input  logic [1:0] region,
  output logic       hit
);
  always_comb begin
    case (bp)
      2'd1:    hit = (region == 2'b11);
      2'd2:    hit = region[1];
      2'd3:    hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_mem_array.sv
`timescale 1ns/1ps
module spi_mem_array #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/spi_mem_slave.sv
`timescale 1ns/1ps
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int DEPTH        = 2048,
  parameter int DATA_W       = 8,
  parameter int ADDR_FIELD_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic hold_n,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe
);
  localparam int AW   = $clog2(DEPTH);
  localparam int BW   = $clog2(DATA_W);
  localparam int AB   = ADDR_FIELD_W / DATA_W;
  localparam int ABW  = $clog2(AB);
  localparam int HI_W = AW - DATA_W;

  // synchronized pins: {cs_n, hold_n, wp_n, sck, mosi}
  logic [4:0] pins_s;
  logic cs_s, hold_s, wp_s, sck_s, mosi_s;

  spi_mem_sync #(.W(5), .INIT(5'b11100)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, hold_n, wp_n, sck, mosi}),
    .q(pins_s)
  );
  assign {cs_s, hold_s, wp_s, sck_s, mosi_s} = pins_s;

  st_t               state_q;
  logic              cs_q, sck_q;
  logic [BW-1:0]     bit_cnt;
  logic [DATA_W-2:0] sh_in;
  logic [DATA_W-1:0] out_sh;
  logic [AW-1:0]     addr_q;
  logic [HI_W-1:0]   addr_hi;
  logic [ABW-1:0]    abyte;
  logic              is_read, wel_q, wr_done, rd_pend, drv;
  logic [1:0]        bp_q;

  logic              cs_fall, cs_rise, sck_rise, sck_fall, byte_end, prot_hit, rd_state;
  logic [DATA_W-1:0] byte_in, st_byte, mem_rd;
  logic [AW-1:0]     next_addr, mem_ra;
  logic              mem_we, mem_re;

  assign cs_fall  = hold_s && cs_q && !cs_s;
  assign cs_rise  = hold_s && !cs_q && cs_s;
  assign sck_rise = hold_s && !cs_s && (state_q != ST_IDLE) && !sck_q && sck_s;
  assign sck_fall = hold_s && !cs_s && (state_q != ST_IDLE) && sck_q && !sck_s;
  assign byte_in  = {sh_in, mosi_s};
  assign byte_end = sck_rise && (bit_cnt == BW'(DATA_W - 1));
  assign rd_state = (state_q == ST_RDATA) || (state_q == ST_RDSR);
  assign next_addr = {addr_hi, byte_in};

  always_comb begin
    st_byte      = '0;
    st_byte[1]   = wel_q;
    st_byte[3:2] = bp_q;
  end

  spi_mem_prot u_prot (.bp(bp_q), .region(addr_q[AW-1:AW-2]), .hit(prot_hit));

  assign mem_we = byte_end && (state_q == ST_WDATA) && wel_q && !prot_hit;
  assign mem_re = byte_end && ((state_q == ST_RDATA) ||
                  ((state_q == ST_ADDR) && is_read && (abyte == ABW'(AB - 1))));
  assign mem_ra = (state_q == ST_ADDR) ? next_addr : addr_q + 1'b1;

  spi_mem_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .wa(addr_q), .wd(byte_in),
    .re(mem_re), .ra(mem_ra), .rd(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      sh_in   <= '0;
      out_sh  <= '0;
      addr_q  <= '0;
      addr_hi <= '0;
      abyte   <= '0;
      is_read <= 1'b0;
      wel_q   <= 1'b0;
      bp_q    <= 2'b00;
      wr_done <= 1'b0;
      rd_pend <= 1'b0;
      drv     <= 1'b0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      cs_q    <= cs_s;
      sck_q   <= sck_s;
      rd_pend <= mem_re;
      if (rd_pend) out_sh <= mem_rd;

      if (cs_fall) begin
        state_q <= ST_OP;
        bit_cnt <= '0;
        drv     <= 1'b0;
        wr_done <= 1'b0;
      end else if (cs_rise) begin
        state_q <= ST_IDLE;
        drv     <= 1'b0;
        wr_done <= 1'b0;
        if (wr_done) wel_q <= 1'b0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        sh_in   <= byte_in[DATA_W-2:0];
        if (byte_end) begin
          case (state_q)
            ST_OP: begin
              case (byte_in)
                OP_WREN:  begin wel_q <= 1'b1; state_q <= ST_SKIP; end
                OP_WRDI:  begin wel_q <= 1'b0; state_q <= ST_SKIP; end
                OP_RDSR:  begin out_sh <= st_byte; state_q <= ST_RDSR; end
                OP_WRSR:  state_q <= ST_WRSR;
                OP_READ:  begin is_read <= 1'b1; abyte <= '0; state_q <= ST_ADDR; end
                OP_WRITE: begin is_read <= 1'b0; abyte <= '0; state_q <= ST_ADDR; end
                default:  state_q <= ST_SKIP;
              endcase
            end
            ST_ADDR: begin
              addr_hi <= next_addr[HI_W-1:0];
              if (abyte == ABW'(AB - 1)) begin
                addr_q  <= next_addr;
                state_q <= is_read ? ST_RDATA : ST_WDATA;
              end else begin
                abyte <= abyte + 1'b1;
              end
            end
            ST_WDATA: begin
              addr_q  <= addr_q + 1'b1;
              wr_done <= 1'b1;
            end
            ST_RDATA: addr_q <= addr_q + 1'b1;
            ST_RDSR:  out_sh <= st_byte;
            ST_WRSR: begin
              if (wel_q && wp_s) bp_q <= byte_in[3:2];
              wr_done <= 1'b1;
              state_q <= ST_SKIP;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && rd_state) begin
        miso   <= out_sh[DATA_W-1];
        out_sh <= out_sh << 1;
        drv    <= 1'b1;
      end

      miso_oe <= drv && rd_state && !cs_s && hold_s;
    end
  end
endmodule

// File: rtl/spi_mem_chk.sv
`timescale 1ns/1ps
module spi_mem_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       hold_n,
  input logic       miso_oe,
  input logic       mem_we,
  input logic       wel,
  input logic [1:0] bp,
  input logic [1:0] region,
  input logic       wp_s
);
  // R2: output released within three clocks of chip select going high
  p_cs_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

  // R11: output released within three clocks of hold going low
  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2) && !$past(hold_n, 3)) |-> !miso_oe);

  // R7: array write only with latch set
  p_wel_gate_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel);

  // R9: no write into fenced region
  p_prot_fence_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (bp == 2'd0 || (bp == 2'd1 && region != 2'b11) || (bp == 2'd2 && !region[1])));

  // R10: protect bits change only with pin released and latch set
  p_wp_lock_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> ($past(wp_s) && $past(wel)));
endmodule

bind spi_mem_slave spi_mem_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .hold_n(hold_n), .miso_oe(miso_oe),
  .mem_we(mem_we), .wel(wel_q), .bp(bp_q), .region(addr_q[AW-1:AW-2]), .wp_s(wp_s)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;
  localparam int HB = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic miso, miso_oe;

  int total = 0, bad = 0, cyc = 0;
  bit mode3 = 1'b0, oe_any = 1'b0, oe_gap = 1'b0, done = 1'b0;
  logic [7:0] got_q[$], exp_q[$];
  string      req_q[$];

  always #2.5 clk = ~clk;

  spi_mem_slave dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] expv, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: compares read bytes against expectations queued by the driver
  always @(negedge clk) begin
    logic [7:0] g, e;
    string r;
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      g = got_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(g === e, r, g, e, "read byte");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_hold(input string req);
    hold_n = 1'b0;
    wait_n(HB);
    check(miso_oe === 1'b0, req, {7'd0, miso_oe}, 8'h00, "oe during hold");
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; wait_n(4);
      sck = 1'b0; wait_n(4);
    end
    hold_n = 1'b1;
    wait_n(HB);
  endtask

  task automatic xfer(input logic [7:0] tx, input bit sample, input int hold_bit,
                      input string req);
    logic [7:0] rx;
    rx = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      if (mode3) begin sck = 1'b0; wait_n(HB); end
      if (hold_bit == i) do_hold(req);
      mosi = tx[i];
      wait_n(HB);
      rx[i] = miso;
      if (sample && miso_oe !== 1'b1) oe_gap = 1'b1;
      if (!sample && miso_oe !== 1'b0) oe_any = 1'b1;
      sck = 1'b1;
      wait_n(HB);
      if (!mode3) begin sck = 1'b0; wait_n(HB); end
    end
    if (sample) got_q.push_back(rx);
  endtask

  task automatic begin_tx;
    sck = mode3; wait_n(4);
    cs_n = 1'b0; wait_n(HB);
  endtask

  task automatic end_tx;
    wait_n(4); cs_n = 1'b1; wait_n(8);
  endtask

  task automatic cmd(input logic [7:0] op);
    begin_tx; xfer(op, 1'b0, -1, ""); end_tx;
  endtask

  task automatic write_mem(input logic [15:0] a, input logic [7:0] d[$]);
    begin_tx;
    xfer(8'h02, 1'b0, -1, ""); xfer(a[15:8], 1'b0, -1, ""); xfer(a[7:0], 1'b0, -1, "");
    foreach (d[i]) xfer(d[i], 1'b0, -1, "");
    end_tx;
  endtask

  task automatic read_mem(input logic [15:0] a, input logic [7:0] e[$], input string req,
                          input int hold_addr, input int hold_data);
    begin_tx;
    xfer(8'h03, 1'b0, -1, req); xfer(a[15:8], 1'b0, hold_addr, req); xfer(a[7:0], 1'b0, -1, req);
    foreach (e[i]) begin
      exp_q.push_back(e[i]); req_q.push_back(req);
      xfer(8'h00, 1'b1, (i == 0) ? hold_data : -1, req);
    end
    end_tx;
  endtask

  task automatic rdsr(input logic [7:0] e, input int n, input string req);
    begin_tx;
    xfer(8'h05, 1'b0, -1, req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e); req_q.push_back(req);
      xfer(8'h00, 1'b1, -1, req);
    end
    end_tx;
  endtask

  task automatic wrsr(input logic [7:0] v);
    begin_tx; xfer(8'h01, 1'b0, -1, ""); xfer(v, 1'b0, -1, ""); end_tx;
  endtask

  initial begin
    wait_n(6);
    rst = 1'b0;
    wait_n(4);
    check(miso_oe === 1'b0, "R2", {7'd0, miso_oe}, 8'h00, "oe after reset");

    // R6 R4 R1 mode 0: write then immediate read, junk in upper address bits
    mode3 = 1'b0;
    cmd(8'h06);
    oe_any = 1'b0;
    write_mem(16'h0010, '{8'h11, 8'h22});
    check(oe_any == 1'b0, "R12", {7'd0, oe_any}, 8'h00, "oe while writing");
    read_mem(16'hF810, '{8'h11, 8'h22}, "R6", -1, -1);
    // R7: latch cleared by completed write
    rdsr(8'h00, 1, "R7");
    // R7: write without latch has no effect
    write_mem(16'h0010, '{8'hAA});
    read_mem(16'h0010, '{8'h11}, "R7", -1, -1);
    // R8: status repeats, bit 1 is latch; R3 clear opcode
    cmd(8'h06);
    rdsr(8'h02, 2, "R8");
    cmd(8'h04);
    rdsr(8'h00, 1, "R3");

    // R5 R1 mode 3: stream across the wrap
    mode3 = 1'b1;
    cmd(8'h06);
    write_mem(16'h07FE, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});
    read_mem(16'h07FE, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, "R5", -1, -1);
    mode3 = 1'b0;

    // R9: upper quarter fenced
    cmd(8'h06);
    write_mem(16'h05FF, '{8'h55, 8'h66});
    cmd(8'h06);
    wrsr(8'h04);
    rdsr(8'h04, 1, "R8");
    cmd(8'h06);
    write_mem(16'h05FF, '{8'h77, 8'h88});
    read_mem(16'h05FF, '{8'h77, 8'h66}, "R9", -1, -1);

    // R10: pin low locks status
    wp_n = 1'b0;
    cmd(8'h06);
    wrsr(8'h0C);
    rdsr(8'h04, 1, "R10");
    wp_n = 1'b1;
    cmd(8'h06);
    wrsr(8'h08);
    rdsr(8'h08, 1, "R10");
    // R9: upper half fenced
    cmd(8'h06);
    write_mem(16'h05FF, '{8'hEE});
    read_mem(16'h05FF, '{8'h77}, "R9", -1, -1);
    // R9: whole array fenced
    cmd(8'h06);
    wrsr(8'h0C);
    cmd(8'h06);
    write_mem(16'h0010, '{8'h99});
    read_mem(16'h0010, '{8'h11}, "R9", -1, -1);
    cmd(8'h06);
    wrsr(8'h00);
    rdsr(8'h00, 1, "R9");

    // R11: hold in address and mid data byte, both modes
    read_mem(16'h07FE, '{8'hA0, 8'hA1}, "R11", 3, 4);
    mode3 = 1'b1;
    read_mem(16'h0010, '{8'h11, 8'h22}, "R11", 6, 2);
    mode3 = 1'b0;

    // R3: unknown opcode makes rest of transaction inert
    cmd(8'h06);
    oe_any = 1'b0;
    begin_tx;
    xfer(8'hA5, 1'b0, -1, ""); xfer(8'h00, 1'b0, -1, "");
    xfer(8'h10, 1'b0, -1, ""); xfer(8'h5A, 1'b0, -1, "");
    end_tx;
    check(oe_any == 1'b0, "R12", {7'd0, oe_any}, 8'h00, "oe after unknown opcode");
    read_mem(16'h0010, '{8'h11}, "R3", -1, -1);
    rdsr(8'h02, 1, "R3");
    cmd(8'h04);

    // R2: clock and data toggled with chip select high
    for (int k = 0; k < 16; k++) begin
      mosi = k[0]; sck = 1'b1; wait_n(4);
      check(miso_oe === 1'b0, "R2", {7'd0, miso_oe}, 8'h00, "oe while deselected");
      sck = 1'b0; wait_n(4);
    end
    rdsr(8'h00, 1, "R2");

    wait_n(20);
    check(exp_q.size() == 0, "R1", 8'(exp_q.size()), 8'h00, "pending reads");
    check(oe_gap == 1'b0, "R12", {7'd0, oe_gap}, 8'h00, "oe low during read");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule